// File: doc/BRIEF.md
# Dual-button long-press reset generator

This block turns a deliberate two-handed gesture into a system reset. It watches two active-low push-button lines and reacts only when both are pressed together. It drives two active-low outputs. The first, the both-held indication, goes low once the two buttons have been held together for a short qualification delay. The second, the reset output, issues one fixed-length low pulse once the joint hold has lasted past a longer setup time.

All durations are counted in ticks. A tick is a clock cycle in which the `tick` enable input is high, so a slow timebase can be shared with other blocks. Each button line is brought into the clock domain by a two-flop synchroniser before any timing logic sees it. The qualification delay, setup time and pulse length are parameters. `SETUP_TICKS` must be at least `HELD_TICKS`.

A press that is held for a long time still produces only one pulse. Before another pulse can start, both buttons must be seen released after the pulse has ended.

Top module: `dual_button_reset`

## Requirements
- R1: Neither output goes low unless both `btn_n` bits are low at the same time; a single held button leaves `held_n` and `rst_out_n` high indefinitely.
- R2: With both buttons held, `held_n` goes low after `HELD_TICKS` ticks counted from the cycle the synchronised inputs both read low. With a tick every cycle, it goes low at the 5th rising edge after both inputs fall when `HELD_TICKS`=3, and not before.
- R3: The reset pulse starts after `SETUP_TICKS` ticks of continuous joint hold. `rst_out_n` goes low at rising edge `SETUP_TICKS`+3 after both inputs fall when a tick occurs every cycle.
- R4: Every reset pulse holds `rst_out_n` low for exactly `PULSE_TICKS` ticks and then returns high.
- R5: A joint hold produces exactly one reset pulse, however long it lasts.
- R6: If either synchronised input goes high before a threshold is reached, the hold count returns to zero. No pulse follows for that attempt, and the next hold needs the full delays again.
- R7: `held_n` returns high at the second rising edge after either button is released.
- R8: Once started, a reset pulse runs its full length even if the buttons are released during it.
- R9: After a pulse, no new pulse may start until both synchronised inputs have read high together while `rst_out_n` is high. Releasing and re-pressing only one button does not re-arm the block.
- R10: Counting advances only in cycles where `tick` is high. With `tick` low, neither the hold count nor the pulse length advances.
- R11: While `rst_n` is low at a clock edge, both outputs go high, the counters clear and the block is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase enable; one tick per high cycle |
| btn_n | input | 2 | Active-low button lines, asynchronous |
| held_n | output | 1 | Active-low both-held indication |
| rst_out_n | output | 1 | Active-low reset pulse |

## Verification
The bench builds the block with `HELD_TICKS`=3, `SETUP_TICKS`=6 and `PULSE_TICKS`=5. These values let every threshold, pulse edge and re-arm sequence be checked at its exact cycle within a few dozen clocks. Holding `tick` high for most of the run makes each edge land at a cycle that can be counted by hand. Stretches with `tick` low show that both the hold count and the pulse length freeze. A long hold far past the setup time shows that the pulse is issued once, and a reset applied in the middle of a pulse shows the return to the reset state.

// File: rtl/dbr_pkg.sv
// Package: shared constants and types for the dual-button reset generator.
// Assumes: exactly two buttons; synchroniser depth fixed at two stages.
package dbr_pkg;
    localparam int unsigned NUM_BTN     = 2;
    localparam int unsigned SYNC_STAGES = 2;
    typedef logic [NUM_BTN-1:0] btn_vec_t;
endpackage

// File: rtl/dbr_sync.sv
// Module: dbr_sync
// Brings one asynchronous active-low line into the clock domain through a
// chain of flops. Assumes the input is slow compared with the clock. Resets
// to the released (high) level.
module dbr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic dout_n
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din_n};
    end

    assign dout_n = chain[STAGES-1];
endmodule

// File: rtl/dbr_hold_timer.sv
// Module: dbr_hold_timer
// Counts ticks while both synchronised buttons are low and saturates at the
// setup count. Any release clears the count. It drives the both-held
// indication and flags when the setup count has been reached.
// Assumes SETUP_TICKS >= HELD_TICKS >= 1.
module dbr_hold_timer #(
    parameter int unsigned HELD_TICKS  = 1500,
    parameter int unsigned SETUP_TICKS = 6000,
    localparam int unsigned CNT_W      = $clog2(SETUP_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic both_low,
    output logic held_n,
    output logic setup_hit
);
    logic [CNT_W-1:0] hold_cnt;

    // Advance the saturating hold count on ticks; clear it on any release.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    hold_cnt <= '0;
        else if (!both_low)                            hold_cnt <= '0;
        else if (tick && hold_cnt != CNT_W'(SETUP_TICKS)) hold_cnt <= hold_cnt + 1'b1;
    end

    // Decode the two thresholds from the current count.
    always_comb begin
        held_n    = !(both_low && (hold_cnt >= CNT_W'(HELD_TICKS)));
        setup_hit = both_low && (hold_cnt == CNT_W'(SETUP_TICKS));
    end
endmodule

// File: rtl/dbr_pulse_gen.sv
// Module: dbr_pulse_gen
// Issues one reset pulse of PULSE_TICKS ticks when the setup count is hit
// while the block is armed. Firing disarms it. It re-arms only when both
// buttons read high while no pulse is running. Assumes PULSE_TICKS >= 1.
module dbr_pulse_gen #(
    parameter int unsigned PULSE_TICKS = 200,
    localparam int unsigned PW         = $clog2(PULSE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic setup_hit,
    input  logic both_high,
    output logic rst_out_n
);
    logic          armed;
    logic          active;
    logic [PW-1:0] pulse_cnt;
    logic          fire;

    // Start condition for a new pulse.
    always_comb fire = armed && setup_hit && !active;

    // Track whether a new pulse is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)                   armed <= 1'b1;
        else if (fire)                armed <= 1'b0;
        else if (both_high && !active) armed <= 1'b1;
    end

    // Run the pulse for its full tick length once started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            pulse_cnt <= '0;
        end else if (fire) begin
            active    <= 1'b1;
            pulse_cnt <= '0;
        end else if (active && tick) begin
            if (pulse_cnt == PW'(PULSE_TICKS - 1)) active <= 1'b0;
            else                                    pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    assign rst_out_n = !active;
endmodule

// File: rtl/dual_button_reset.sv
// Module: dual_button_reset (top)
// Two-button long-press reset generator. It synchronises both buttons,
// times the joint hold and drives the both-held indication and a single
// reset pulse. Assumes SETUP_TICKS >= HELD_TICKS and a synchronous
// active-low reset.
module dual_button_reset #(
    parameter int unsigned HELD_TICKS  = 1500,
    parameter int unsigned SETUP_TICKS = 6000,
    parameter int unsigned PULSE_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] btn_n,
    output logic       held_n,
    output logic       rst_out_n
);
    import dbr_pkg::*;

    btn_vec_t sync_n;
    logic     both_low;
    logic     both_high;
    logic     setup_hit;

    // One synchroniser per button line.
    for (genvar i = 0; i < NUM_BTN; i++) begin : g_sync
        dbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_n  (btn_n[i]),
            .dout_n (sync_n[i])
        );
    end

    // Joint-state decode of the synchronised buttons.
    always_comb begin
        both_low  = (sync_n == '0);
        both_high = (sync_n == '1);
    end

    dbr_hold_timer #(
        .HELD_TICKS  (HELD_TICKS),
        .SETUP_TICKS (SETUP_TICKS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .both_low  (both_low),
        .held_n    (held_n),
        .setup_hit (setup_hit)
    );

    dbr_pulse_gen #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .setup_hit (setup_hit),
        .both_high (both_high),
        .rst_out_n (rst_out_n)
    );
endmodule

// File: rtl/dbr_checker.sv
// Module: dbr_checker
// Property checks for dual_button_reset, bound to every instance of the top.
// Window lengths come from a counter held here, not from long $past chains.
module dbr_checker #(
    parameter int unsigned PULSE_TICKS = 200,
    localparam int unsigned CW         = $clog2(PULSE_TICKS + 2)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] btn_n,
    input logic [1:0] sync_n,
    input logic       held_n,
    input logic       rst_out_n
);
    logic [CW-1:0] low_ticks;
    logic          rel_seen;

    // Count the ticks seen while the reset output is low.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_out_n) low_ticks <= '0;
        else if (tick)           low_ticks <= low_ticks + 1'b1;
    end

    // Remember whether both buttons were seen released since the last pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rel_seen <= 1'b1;
        else if (!rst_out_n)                 rel_seen <= 1'b0;
        else if (sync_n == 2'b11)            rel_seen <= 1'b1;
    end

    // R1: the indication can only be low if both lines were low two edges ago.
    p_needs_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !held_n |-> ($past(btn_n, 2) == 2'b00));

    // R3: a pulse never starts without the both-held indication already low.
    p_pulse_after_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> !$past(held_n));

    // R4: each pulse spans exactly PULSE_TICKS ticks.
    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (low_ticks == CW'(PULSE_TICKS)));

    // R5 and R9: a new pulse only after a full release.
    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> rel_seen);
endmodule

bind dual_button_reset dbr_checker #(.PULSE_TICKS(PULSE_TICKS)) u_dbr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .btn_n     (btn_n),
    .sync_n    (sync_n),
    .held_n    (held_n),
    .rst_out_n (rst_out_n)
);

// File: tb/dual_button_reset_bench.sv
// Directed bench for dual_button_reset: one task per scenario.
// Inputs change and outputs are sampled at the falling edge of the clock.
module dual_button_reset_bench;
    localparam int unsigned HT = 3;
    localparam int unsigned ST = 6;
    localparam int unsigned PT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] btn_n = 2'b11;
    logic       held_n;
    logic       rst_out_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dual_button_reset #(
        .HELD_TICKS  (HT),
        .SETUP_TICKS (ST),
        .PULSE_TICKS (PT)
    ) u_dual_button_reset (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .btn_n     (btn_n),
        .held_n    (held_n),
        .rst_out_n (rst_out_n)
    );

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Release both buttons and wait until the block is re-armed.
    task automatic release_all();
        btn_n = 2'b11;
        adv(4);
    endtask

    task automatic t_reset_state();
        adv(3);
        chk(held_n, 1'b1, "R11 held_n in reset");
        chk(rst_out_n, 1'b1, "R11 rst_out_n in reset");
        rst_n = 1'b1;
        adv(2);
        chk(held_n, 1'b1, "R11 held_n after reset");
        chk(rst_out_n, 1'b1, "R11 rst_out_n after reset");
    endtask

    task automatic t_single_button();
        btn_n = 2'b10;
        adv(20);
        chk(held_n, 1'b1, "R1 held_n with btn0 only");
        chk(rst_out_n, 1'b1, "R1 rst_out_n with btn0 only");
        btn_n = 2'b01;
        adv(20);
        chk(held_n, 1'b1, "R1 held_n with btn1 only");
        chk(rst_out_n, 1'b1, "R1 rst_out_n with btn1 only");
        release_all();
    endtask

    task automatic t_full_hold();
        btn_n = 2'b00;
        adv(4);  chk(held_n, 1'b1, "R2 held_n before delay");
        adv(1);  chk(held_n, 1'b0, "R2 held_n at delay");
        adv(3);  chk(rst_out_n, 1'b1, "R3 rst_out_n before setup");
        adv(1);  chk(rst_out_n, 1'b0, "R3 rst_out_n at setup");
        adv(4);  chk(rst_out_n, 1'b0, "R4 pulse last tick");
        adv(1);  chk(rst_out_n, 1'b1, "R4 pulse ended");
        adv(25);
        chk(rst_out_n, 1'b1, "R5 no second pulse on long hold");
        chk(held_n, 1'b0, "R5 held_n stays low on long hold");
        btn_n = 2'b11;
        adv(1);  chk(held_n, 1'b0, "R7 held_n one edge after release");
        adv(1);  chk(held_n, 1'b1, "R7 held_n two edges after release");
        adv(2);
    endtask

    task automatic t_abort();
        btn_n = 2'b00;
        adv(6);  chk(held_n, 1'b0, "R6 held_n low before abort");
        btn_n = 2'b11;
        adv(15); chk(rst_out_n, 1'b1, "R6 no pulse after abort");
        btn_n = 2'b00;
        adv(4);  chk(held_n, 1'b1, "R6 count restarted");
        adv(1);  chk(held_n, 1'b0, "R6 held_n after fresh delay");
        adv(3);  chk(rst_out_n, 1'b1, "R6 rst_out_n before fresh setup");
        adv(1);  chk(rst_out_n, 1'b0, "R6 pulse after fresh setup");
        adv(5);  chk(rst_out_n, 1'b1, "R4 pulse ended after retry");
        release_all();
    endtask

    task automatic t_release_in_pulse();
        btn_n = 2'b00;
        adv(9);  chk(rst_out_n, 1'b0, "R8 pulse started");
        btn_n = 2'b11;
        adv(4);  chk(rst_out_n, 1'b0, "R8 pulse held after release");
        adv(1);  chk(rst_out_n, 1'b1, "R8 pulse full length");
        release_all();
    endtask

    task automatic t_partial_rearm();
        btn_n = 2'b00;
        adv(9);  chk(rst_out_n, 1'b0, "R9 first pulse");
        adv(5);  chk(rst_out_n, 1'b1, "R9 first pulse ended");
        btn_n = 2'b01;
        adv(4);
        btn_n = 2'b00;
        adv(20);
        chk(held_n, 1'b0, "R9 held_n after partial release");
        chk(rst_out_n, 1'b1, "R9 no pulse after partial release");
        release_all();
        btn_n = 2'b00;
        adv(9);  chk(rst_out_n, 1'b0, "R9 pulse after full release");
        adv(5);
        release_all();
    endtask

    task automatic t_tick_gate();
        tick = 1'b0;
        btn_n = 2'b00;
        adv(30);
        chk(held_n, 1'b1, "R10 no count without tick");
        chk(rst_out_n, 1'b1, "R10 no pulse without tick");
        tick = 1'b1;
        adv(2);  chk(held_n, 1'b1, "R10 two ticks counted");
        adv(1);  chk(held_n, 1'b0, "R10 delay reached by ticks");
        adv(3);
        adv(1);  chk(rst_out_n, 1'b0, "R10 pulse started by ticks");
        tick = 1'b0;
        adv(10); chk(rst_out_n, 1'b0, "R10 pulse frozen without tick");
        tick = 1'b1;
        adv(4);  chk(rst_out_n, 1'b0, "R10 pulse resumes");
        adv(1);  chk(rst_out_n, 1'b1, "R10 pulse ends after its ticks");
        release_all();
    endtask

    task automatic t_reset_mid_pulse();
        btn_n = 2'b00;
        adv(9);  chk(rst_out_n, 1'b0, "R11 pulse before reset");
        rst_n = 1'b0;
        adv(1);
        chk(rst_out_n, 1'b1, "R11 reset clears pulse");
        chk(held_n, 1'b1, "R11 reset clears indication");
        btn_n = 2'b11;
        adv(4);
        rst_n = 1'b1;
        adv(2);
    endtask

    initial begin
        t_reset_state();
        t_single_button();
        t_full_hold();
        t_abort();
        t_release_in_pulse();
        t_partial_rearm();
        t_tick_gate();
        t_reset_mid_pulse();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule